// File: doc/BRIEF.md
# Palette Colour Lookup Table with Sequenced Register Loading

This block holds a 256-entry colour table, each entry a 24-bit RGB triple with 8 bits per component. A host loads it over a simple 32-bit register bus. One register selects the entry to load. A second register takes the colour components one at a time: red first, then green, then blue. After each blue write the entry pointer steps forward by itself, so a host can stream a whole run of consecutive entries after setting the index once.

A separate lookup port serves a display pipeline. Every clock it accepts an 8-bit pixel code and, one cycle later, returns the registered RGB triple for that code. Bus reads return zero. The bus carries only full 32-bit words and has no byte enables. Reset loads a fixed default table: every entry black except the highest, which is white.

Top module: `pal_dac`

## Requirements
- R1: Only a bus write (`bus_valid`=1, `bus_we`=1) to byte offset 0x0 (index register) or 0x4 (data register) has an effect. Writes to offsets 0x8 or 0xC, reads, and cycles with `bus_valid`=0 change neither the table, the entry pointer nor the component phase.
- R2: A write to offset 0x0 sets the entry pointer to `bus_wdata[31:24]` and returns the component phase to red.
- R3: Successive writes to offset 0x4 place `bus_wdata[31:24]` into the red, then the green, then the blue field of the pointed entry. The lookup output packs red in bits 23:16, green in 15:8 and blue in 7:0.
- R4: A blue write advances the entry pointer by one modulo 256 (255 wraps to 0) and returns the phase to red.
- R5: `bus_rdata` is zero at all times, for any offset.
- R6: While `rst` is high on a clock edge, every entry becomes 0x000000 except entry 255, which becomes 0xFFFFFF, and the pointer and phase clear to 0 and red.
- R7: `pix_rgb` shows the entry selected by the `pix_idx` sampled at the previous rising clock edge.
- R8: When a bus write and a lookup hit the same entry at the same edge, the lookup returns the entry's value from before the write.
- R9: An index write part way through a triple keeps the components already stored in the old entry. The next data write then goes to the red field of the new entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset within the 16-byte register window |
| bus_wdata | input | 32 | Write data; only bits 31:24 are used |
| bus_rdata | output | 32 | Read data, always zero |
| pix_idx | input | 8 | Pixel code to look up |
| pix_rgb | output | 24 | Registered RGB of the looked-up entry |

## Verification
The loading sequence is exercised in several ways:
- A table of distinct triples is streamed into six consecutive entries after one index write. This separates correct automatic advance from writes that pile onto one entry or land in the wrong component.
- A stream that crosses entry 255 shows the wrap to entry 0.
- A triple broken off after green by a new index write separates a phase that restarts at red from one that keeps counting.
- Ignored offsets, reads and unstrobed cycles are placed in the middle of a triple; a later full triple shows whether they disturbed the phase.
- A lookup that coincides with a blue write checks the old-value rule.
- A second reset checks the default table against the loaded one.

// File: rtl/pal_dac_pkg.sv
package pal_dac_pkg;

    localparam int COMP_W = 8;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    typedef struct packed {
        logic [COMP_W-1:0] r;
        logic [COMP_W-1:0] g;
        logic [COMP_W-1:0] b;
    } rgb_t;

    localparam rgb_t RGB_BLACK = '{r: '0, g: '0, b: '0};
    localparam rgb_t RGB_WHITE = '{r: '1, g: '1, b: '1};

    function automatic phase_e phase_after(phase_e p);
        case (p)
            PH_RED:  return PH_GRN;
            PH_GRN:  return PH_BLU;
            default: return PH_RED;
        endcase
    endfunction

    function automatic rgb_t merge_comp(rgb_t cur, phase_e p, logic [COMP_W-1:0] v);
        rgb_t n;
        n = cur;
        case (p)
            PH_RED:  n.r = v;
            PH_GRN:  n.g = v;
            default: n.b = v;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/pal_seq.sv
module pal_seq
    import pal_dac_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [IDX_W-1:0]  cur_idx,
    output phase_e            cur_phase,
    output logic              st_en,
    output logic [IDX_W-1:0]  st_idx,
    output phase_e            st_phase,
    output logic [COMP_W-1:0] st_val
);
    localparam logic [ADDR_W-1:0] OFS_INDEX = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_DATA  = ADDR_W'(4);

    logic              wr_cycle, hit_index, hit_data;
    logic [COMP_W-1:0] top_byte;
    logic              unused_low;

    assign wr_cycle  = bus_valid && bus_we;
    assign hit_index = wr_cycle && (bus_addr == OFS_INDEX);
    assign hit_data  = wr_cycle && (bus_addr == OFS_DATA);
    assign top_byte  = bus_wdata[DATA_W-1 -: COMP_W];
    assign unused_low = &{1'b0, bus_wdata[DATA_W-COMP_W-1:0]};

    assign st_en    = hit_data;
    assign st_idx   = cur_idx;
    assign st_phase = cur_phase;
    assign st_val   = top_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_idx   <= '0;
            cur_phase <= PH_RED;
        end else if (hit_index) begin
            cur_idx   <= top_byte[IDX_W-1:0];
            cur_phase <= PH_RED;
        end else if (hit_data) begin
            cur_phase <= phase_after(cur_phase);
            if (cur_phase == PH_BLU)
                cur_idx <= cur_idx + 1'b1;
        end
    end
endmodule

// File: rtl/pal_store.sv
module pal_store
    import pal_dac_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  phase_e            wr_phase,
    input  logic [COMP_W-1:0] wr_val,
    input  logic [IDX_W-1:0]  rd_idx,
    output rgb_t              rd_rgb
);
    localparam int DEPTH = 1 << IDX_W;

    rgb_t table_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                table_q[i] <= (i == DEPTH - 1) ? RGB_WHITE : RGB_BLACK;
        end else if (wr_en) begin
            table_q[wr_idx] <= merge_comp(table_q[wr_idx], wr_phase, wr_val);
        end
    end

    // Registered read sees the pre-write content on a same-edge collision.
    always_ff @(posedge clk) begin
        if (rst) rd_rgb <= RGB_BLACK;
        else     rd_rgb <= table_q[rd_idx];
    end
endmodule

// File: rtl/pal_dac.sv
module pal_dac
    import pal_dac_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [IDX_W-1:0]  pix_idx,
    output logic [3*COMP_W-1:0] pix_rgb
);
    logic [IDX_W-1:0]  cur_idx;
    phase_e            cur_phase;
    logic              st_en;
    logic [IDX_W-1:0]  st_idx;
    phase_e            st_phase;
    logic [COMP_W-1:0] st_val;
    rgb_t              look_rgb;

    pal_seq #(.IDX_W(IDX_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .cur_idx(cur_idx), .cur_phase(cur_phase),
        .st_en(st_en), .st_idx(st_idx), .st_phase(st_phase), .st_val(st_val)
    );

    pal_store #(.IDX_W(IDX_W)) u_store (
        .clk(clk), .rst(rst),
        .wr_en(st_en), .wr_idx(st_idx), .wr_phase(st_phase), .wr_val(st_val),
        .rd_idx(pix_idx), .rd_rgb(look_rgb)
    );

    assign bus_rdata = '0;
    assign pix_rgb   = look_rgb;
endmodule

// File: rtl/pal_dac_chk.sv
module pal_dac_chk #(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [IDX_W-1:0]  cur_idx,
    input logic [1:0]        cur_phase
);
    logic wr_idx_reg, wr_dat_reg;
    logic unused_chk;
    assign wr_idx_reg = bus_valid && bus_we && (bus_addr == ADDR_W'(0));
    assign wr_dat_reg = bus_valid && bus_we && (bus_addr == ADDR_W'(4));
    assign unused_chk = &{1'b0, bus_wdata[DATA_W-IDX_W-1:0]};

    AST_IGNORED_ACCESS: assert property (@(posedge clk) disable iff (rst)
        !(wr_idx_reg || wr_dat_reg) |=> $stable(cur_idx) && $stable(cur_phase)); // R1
    AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_idx_reg |=> cur_idx == $past(bus_wdata[DATA_W-1 -: IDX_W]) && cur_phase == 2'd0); // R2
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        wr_dat_reg && cur_phase != 2'd2 |=> cur_phase == $past(cur_phase) + 2'd1 && $stable(cur_idx)); // R3
    AST_AUTO_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        wr_dat_reg && cur_phase == 2'd2 |=> cur_idx == IDX_W'($past(cur_idx) + 1'b1) && cur_phase == 2'd0); // R4
    AST_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_rdata == '0); // R5
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> cur_idx == '0 && cur_phase == 2'd0); // R6
endmodule

bind pal_dac pal_dac_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cur_idx(cur_idx), .cur_phase(cur_phase)
);

// File: tb/pal_dac_test.sv
`timescale 1ns/1ps
module pal_dac_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_rgb;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;

    pal_dac uut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pix_idx(pix_idx), .pix_rgb(pix_rgb)
    );

    always #2.5 clk = ~clk;

    localparam logic [23:0] STREAM [6] = '{
        24'h102030, 24'hFF0001, 24'h00FF00, 24'h0000FF, 24'h808080, 24'h5A3CC3
    };

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired: actual %0d cycles expected < 100000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_op(input logic we, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    task automatic set_index(input logic [7:0] i);
        bus_op(1'b1, 4'h0, {i, 24'h0});
    endtask

    task automatic put_comp(input logic [7:0] v);
        bus_op(1'b1, 4'h4, {v, 24'h00A5A5});
    endtask

    task automatic put_rgb(input logic [23:0] c);
        put_comp(c[23:16]); put_comp(c[15:8]); put_comp(c[7:0]);
    endtask

    task automatic look(input string req, input logic [7:0] i, input logic [23:0] exp);
        @(negedge clk);
        pix_idx = i;
        @(posedge clk);
        #1;
        check(req, {8'h0, pix_rgb}, {8'h0, exp});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R6 reset table
        look("R6 entry0 black", 8'd0, 24'h000000);
        look("R6 entry128 black", 8'd128, 24'h000000);
        look("R6 entry255 white", 8'd255, 24'hFFFFFF);
        // R6 pointer at 0 and phase red after reset
        put_comp(8'h12);
        look("R6 first data write hits red of entry0", 8'd0, 24'h120000);

        // R3 R4 R7 streamed table walk
        set_index(8'd10);
        foreach (STREAM[k]) put_rgb(STREAM[k]);
        foreach (STREAM[k]) look("R4 streamed entry", 8'(10 + k), STREAM[k]);
        look("R3 neighbour after stream untouched", 8'd16, 24'h000000);

        // R5 reads return zero at both offsets
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = 4'h4;
        #1 check("R5 read data offset", bus_rdata, 32'h0);
        bus_addr = 4'h0;
        #1 check("R5 read index offset", bus_rdata, 32'h0);
        @(negedge clk) bus_valid = 1'b0;

        // R1 ignored accesses in mid triple
        set_index(8'h20);
        put_comp(8'hC1);
        bus_op(1'b1, 4'h8, 32'h99000000);
        bus_op(1'b1, 4'hC, 32'h98000000);
        bus_op(1'b0, 4'h4, 32'h97000000);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h96000000;
        @(negedge clk);
        bus_we = 1'b0;
        look("R1 partial entry untouched by ignored accesses", 8'h20, 24'hC10000);
        put_comp(8'hC2); put_comp(8'hC3);
        look("R1 triple completes in order", 8'h20, 24'hC1C2C3);
        put_comp(8'hD4);
        look("R1 advance lands on next entry", 8'h21, 24'hD40000);

        // R9 index write interrupts a triple
        set_index(8'h30);
        put_comp(8'hAA); put_comp(8'hBB);
        set_index(8'h31);
        put_rgb(24'h112233);
        look("R9 old entry keeps partial components", 8'h30, 24'hAABB00);
        look("R9 new entry restarted at red", 8'h31, 24'h112233);
        put_comp(8'h44);
        look("R9 advance after interrupted sequence", 8'h32, 24'h440000);

        // R4 wrap from 255 to 0
        set_index(8'hFE);
        put_rgb(24'h0A0B0C);
        put_rgb(24'h0D0E0F);
        put_comp(8'h77);
        look("R4 entry 254", 8'hFE, 24'h0A0B0C);
        look("R4 entry 255 overwritten", 8'hFF, 24'h0D0E0F);
        look("R4 wrap to entry 0", 8'h00, 24'h770000);

        // R8 same-edge write and lookup
        set_index(8'h40);
        put_comp(8'h5E); put_comp(8'h6F);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h7A000000;
        pix_idx = 8'h40;
        @(posedge clk);
        #1 check("R8 colliding lookup returns old value", {8'h0, pix_rgb}, 32'h005E6F00);
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
        @(posedge clk);
        #1 check("R7 next cycle shows new value", {8'h0, pix_rgb}, 32'h005E6F7A);

        // R7 one-cycle latency: change index, output follows one edge later
        @(negedge clk) pix_idx = 8'd10;
        #1 check("R7 output holds before edge", {8'h0, pix_rgb}, 32'h005E6F7A);
        @(posedge clk);
        #1 check("R7 output after edge", {8'h0, pix_rgb}, {8'h0, STREAM[0]});

        // R6 second reset restores defaults
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        look("R6 reset clears loaded entry", 8'd10, 24'h000000);
        look("R6 reset restores white 255", 8'd255, 24'hFFFFFF);
        put_comp(8'h3C);
        look("R6 reset clears pointer", 8'd0, 24'h3C0000);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule